// File: doc/BRIEF.md
# Two-Slot Serial Byte Stage

This block holds up to two bytes between a byte-wide host register port and the shift register of a serial two-wire bus engine. One parameter picks its direction. In the transmit variant, the host pushes bytes and the engine pulls them one at a time when it needs the next byte to shift out. In the receive variant, the engine delivers each completed byte and the host pops bytes in arrival order.

The two variants handle a full stage differently. In the transmit variant, a push into a full stage replaces the newer byte and leaves the older one in place. In the receive variant, an arrival at a full stage is refused: the block tells the engine to answer with a NACK and records an overflow.

A single request flag means "room available" when transmitting and "data waiting" when receiving. This flag is steered either to an interrupt request or to a DMA request. A flush input empties the stage.

Top module: `twoslot_byte_stage`

## Requirements
- R1: After reset, `level_o` is 0 and `overflow_o` is 0. The request flag reads 1 in the transmit variant and 0 in the receive variant.
- R2: Transmit variant: a push into an empty stage becomes the head. From the next cycle, `eng_rdata_o` shows that byte and `level_o` is 1.
- R3: Transmit variant: a push while a head is held stays behind the head. A push into a full stage (no pull in the same cycle) replaces that second byte, with `level_o` staying 2 and the head unchanged.
- R4: Transmit variant: the head leaves only in a cycle with `eng_stb_i` high. In that cycle `eng_ack_o` is 1 and `eng_rdata_o` carries the head, and the second byte becomes head at the next edge. A pull from an empty stage gives `eng_nack_o` = 1 and `eng_ack_o` = 0.
- R5: Receive variant: bytes arriving with `eng_stb_i` are presented to the host on `host_rdata_o` in arrival order. A pop with `host_stb_i` removes the oldest byte, and each accepted arrival is marked by `eng_ack_o` = 1 in its cycle.
- R6: Receive variant: an arrival while two bytes are held and no pop occurs in the same cycle is refused. In that cycle `eng_nack_o` = 1 and `eng_ack_o` = 0, the contents are unchanged, and `overflow_o` becomes 1 at the next edge and stays 1 until a flush. An arrival in the same cycle as a pop from a full stage is accepted.
- R7: The request flag is 1 while `level_o` < 2 (transmit variant) or while `level_o` > 0 (receive variant). It appears on `irq_req_o` when `dma_mode_i` = 0 and on `dma_req_o` when `dma_mode_i` = 1; the other output is held at 0.
- R8: `flush_i` empties the stage and clears `overflow_o` at the next edge. It wins over a push, pull, pop or arrival in the same cycle, so that cycle shows neither `eng_ack_o` nor `eng_nack_o`.
- R9: `level_o` encodes the bytes held as 0, 1 or 2 and never reads 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Empty the stage |
| dma_mode_i | input | 1 | Steer the request flag to DMA (1) or interrupt (0) |
| host_stb_i | input | 1 | Host push (transmit) or pop (receive) |
| host_wdata_i | input | DATA_W | Byte pushed by the host (transmit) |
| host_rdata_o | output | DATA_W | Oldest byte held (receive), 0 in transmit |
| eng_stb_i | input | 1 | Engine pull (transmit) or arrival (receive) |
| eng_wdata_i | input | DATA_W | Completed byte from the engine (receive) |
| eng_rdata_o | output | DATA_W | Head byte for the engine (transmit), 0 in receive |
| eng_ack_o | output | 1 | Byte handed out or accepted this cycle |
| eng_nack_o | output | 1 | Underrun (transmit) or refusal (receive) this cycle |
| level_o | output | 2 | Bytes held: 0, 1 or 2 |
| overflow_o | output | 1 | Sticky refused-arrival flag (receive) |
| irq_req_o | output | 1 | Request flag in interrupt mode |
| dma_req_o | output | 1 | Request flag in DMA mode |

## Verification
The transmit variant is run through a table of push and pull combinations from every fill level. These include a push alone, a pull alone, a push together with a pull at level one and at level two, and a push into a full stage. The table separates true first-in order from the overwrite of the newer byte and from underrun.

The receive variant is driven with arrivals against a full stage, both with and without a pop in the same cycle. This separates refusal from acceptance and shows that the overflow flag stays set. Flush is applied together with competing strobes to show its priority, and the mode input is toggled to show where the request flag is routed.

// File: rtl/twoslot_stage_pkg.sv
package twoslot_stage_pkg;

   typedef enum logic {
      STAGE_TX = 1'b0,
      STAGE_RX = 1'b1
   } stage_dir_e;

   localparam int LEVEL_W = 2;

   function automatic logic [LEVEL_W-1:0] fill_count(input logic a, input logic b);
      return LEVEL_W'(a) + LEVEL_W'(b);
   endfunction

endpackage

// File: rtl/twoslot_tx_core.sv
module twoslot_tx_core #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pull,
   output logic [DATA_W-1:0] head_data,
   output logic              head_vld,
   output logic              tail_vld,
   output logic              taken,
   output logic              underrun
);

   logic [DATA_W-1:0] slot_head_q, slot_tail_q;
   logic              vld_head_q, vld_tail_q;
   logic [DATA_W-1:0] slot_head_d, slot_tail_d;
   logic              vld_head_d, vld_tail_d;
   logic              shift_out, accept;

   assign shift_out = pull && vld_head_q && !flush;
   assign accept    = push && !flush;
   assign taken     = shift_out;
   assign underrun  = pull && !vld_head_q && !flush;

   always_comb begin
      slot_head_d = slot_head_q;
      slot_tail_d = slot_tail_q;
      vld_head_d  = vld_head_q;
      vld_tail_d  = vld_tail_q;
      if (shift_out) begin
         slot_head_d = slot_tail_q;
         vld_head_d  = vld_tail_q;
         vld_tail_d  = 1'b0;
      end
      if (accept) begin
         if (!vld_head_d) begin
            slot_head_d = push_data;
            vld_head_d  = 1'b1;
         end else begin
            slot_tail_d = push_data;
            vld_tail_d  = 1'b1;
         end
      end
      if (flush) begin
         vld_head_d = 1'b0;
         vld_tail_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_head_q <= '0;
         slot_tail_q <= '0;
         vld_head_q  <= 1'b0;
         vld_tail_q  <= 1'b0;
      end else begin
         slot_head_q <= slot_head_d;
         slot_tail_q <= slot_tail_d;
         vld_head_q  <= vld_head_d;
         vld_tail_q  <= vld_tail_d;
      end
   end

   assign head_data = slot_head_q;
   assign head_vld  = vld_head_q;
   assign tail_vld  = vld_tail_q;

endmodule

// File: rtl/twoslot_rx_core.sv
module twoslot_rx_core #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              arrive,
   input  logic [DATA_W-1:0] arrive_data,
   input  logic              pop,
   output logic [DATA_W-1:0] out_data,
   output logic              out_vld,
   output logic              back_vld,
   output logic              accepted,
   output logic              refused,
   output logic              ovf
);

   logic [DATA_W-1:0] slot_out_q, slot_back_q;
   logic              vld_out_q, vld_back_q, ovf_q;
   logic [DATA_W-1:0] slot_out_d, slot_back_d;
   logic              vld_out_d, vld_back_d;
   logic              do_pop, do_take;

   assign do_pop   = pop && vld_out_q && !flush;
   assign do_take  = arrive && !flush && (!vld_back_q || do_pop);
   assign accepted = do_take;
   assign refused  = arrive && !flush && !do_take;

   always_comb begin
      slot_out_d  = slot_out_q;
      slot_back_d = slot_back_q;
      vld_out_d   = vld_out_q;
      vld_back_d  = vld_back_q;
      if (do_pop) begin
         slot_out_d = slot_back_q;
         vld_out_d  = vld_back_q;
         vld_back_d = 1'b0;
      end
      if (do_take) begin
         if (!vld_out_d) begin
            slot_out_d = arrive_data;
            vld_out_d  = 1'b1;
         end else begin
            slot_back_d = arrive_data;
            vld_back_d  = 1'b1;
         end
      end
      if (flush) begin
         vld_out_d  = 1'b0;
         vld_back_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_out_q  <= '0;
         slot_back_q <= '0;
         vld_out_q   <= 1'b0;
         vld_back_q  <= 1'b0;
         ovf_q       <= 1'b0;
      end else begin
         slot_out_q  <= slot_out_d;
         slot_back_q <= slot_back_d;
         vld_out_q   <= vld_out_d;
         vld_back_q  <= vld_back_d;
         if (flush)        ovf_q <= 1'b0;
         else if (refused) ovf_q <= 1'b1;
      end
   end

   assign out_data = slot_out_q;
   assign out_vld  = vld_out_q;
   assign back_vld = vld_back_q;
   assign ovf      = ovf_q;

endmodule

// File: rtl/twoslot_req_unit.sv
module twoslot_req_unit
   import twoslot_stage_pkg::*;
#(
   parameter stage_dir_e DIR = STAGE_TX
) (
   input  logic               first_vld,
   input  logic               second_vld,
   input  logic               dma_mode,
   output logic [LEVEL_W-1:0] level,
   output logic               irq_req,
   output logic               dma_req
);

   logic flag;

   assign level = fill_count(first_vld, second_vld);

   generate
      if (DIR == STAGE_RX) begin : g_rx_flag
         assign flag = first_vld;
      end else begin : g_tx_flag
         assign flag = !(first_vld && second_vld);
      end
   endgenerate

   assign irq_req = flag && !dma_mode;
   assign dma_req = flag && dma_mode;

endmodule

// File: rtl/twoslot_byte_stage.sv
module twoslot_byte_stage
   import twoslot_stage_pkg::*;
#(
   parameter int         DATA_W = 8,
   parameter stage_dir_e DIR    = STAGE_TX
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              dma_mode_i,
   input  logic              host_stb_i,
   input  logic [DATA_W-1:0] host_wdata_i,
   output logic [DATA_W-1:0] host_rdata_o,
   input  logic              eng_stb_i,
   input  logic [DATA_W-1:0] eng_wdata_i,
   output logic [DATA_W-1:0] eng_rdata_o,
   output logic              eng_ack_o,
   output logic              eng_nack_o,
   output logic [1:0]        level_o,
   output logic              overflow_o,
   output logic              irq_req_o,
   output logic              dma_req_o
);

   logic first_vld, second_vld;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("twoslot_byte_stage: DATA_W must be at least 1");
      end
      if (LEVEL_W != 2) begin : g_bad_level
         $error("twoslot_byte_stage: level encoding must be two bits");
      end

      if (DIR == STAGE_TX) begin : g_tx
         logic unused_rx_in;
         assign unused_rx_in = ^eng_wdata_i;
         twoslot_tx_core #(.DATA_W(DATA_W)) u_core (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush_i),
            .push      (host_stb_i),
            .push_data (host_wdata_i),
            .pull      (eng_stb_i),
            .head_data (eng_rdata_o),
            .head_vld  (first_vld),
            .tail_vld  (second_vld),
            .taken     (eng_ack_o),
            .underrun  (eng_nack_o)
         );
         assign host_rdata_o = '0;
         assign overflow_o   = 1'b0;
      end else begin : g_rx
         logic unused_tx_in;
         assign unused_tx_in = ^host_wdata_i;
         twoslot_rx_core #(.DATA_W(DATA_W)) u_core (
            .clk         (clk),
            .rst_n       (rst_n),
            .flush       (flush_i),
            .arrive      (eng_stb_i),
            .arrive_data (eng_wdata_i),
            .pop         (host_stb_i),
            .out_data    (host_rdata_o),
            .out_vld     (first_vld),
            .back_vld    (second_vld),
            .accepted    (eng_ack_o),
            .refused     (eng_nack_o),
            .ovf         (overflow_o)
         );
         assign eng_rdata_o = '0;
      end
   endgenerate

   twoslot_req_unit #(.DIR(DIR)) u_req (
      .first_vld  (first_vld),
      .second_vld (second_vld),
      .dma_mode   (dma_mode_i),
      .level      (level_o),
      .irq_req    (irq_req_o),
      .dma_req    (dma_req_o)
   );

endmodule

// File: rtl/twoslot_byte_stage_chk.sv
module twoslot_byte_stage_chk
   import twoslot_stage_pkg::*;
#(
   parameter int         DATA_W = 8,
   parameter stage_dir_e DIR    = STAGE_TX
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush_i,
   input logic              dma_mode_i,
   input logic              host_stb_i,
   input logic [DATA_W-1:0] host_wdata_i,
   input logic [DATA_W-1:0] host_rdata_o,
   input logic              eng_stb_i,
   input logic [DATA_W-1:0] eng_wdata_i,
   input logic [DATA_W-1:0] eng_rdata_o,
   input logic              eng_ack_o,
   input logic              eng_nack_o,
   input logic [1:0]        level_o,
   input logic              overflow_o,
   input logic              irq_req_o,
   input logic              dma_req_o
);

   a_r9_level_range: assert property (@(posedge clk) disable iff (!rst_n)
      level_o != 2'd3);

   a_r7_one_request_path: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_req_o && dma_req_o));

   a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (level_o == 2'd0) && !overflow_o);

   a_r8_flush_silences: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |-> !eng_ack_o && !eng_nack_o);

   a_r4_strobe_needed: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_ack_o || eng_nack_o) |-> eng_stb_i);

   a_r4_ack_nack_apart: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({eng_ack_o, eng_nack_o}) <= 1);

   generate
      if (DIR == STAGE_TX) begin : g_tx_props
         a_r3_overwrite_keeps_head: assert property (@(posedge clk) disable iff (!rst_n)
            (level_o == 2'd2) && host_stb_i && !eng_stb_i && !flush_i
            |=> (level_o == 2'd2) && $stable(eng_rdata_o));
         a_r4_no_pull_keeps_head: assert property (@(posedge clk) disable iff (!rst_n)
            (level_o != 2'd0) && !eng_stb_i && !flush_i |=> $stable(eng_rdata_o));
      end else begin : g_rx_props
         a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            overflow_o && !flush_i |=> overflow_o);
         a_r6_refusal_sets_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            eng_nack_o |=> overflow_o && (level_o == 2'd2) && $stable(host_rdata_o));
      end
   endgenerate

endmodule

bind twoslot_byte_stage twoslot_byte_stage_chk #(.DATA_W(DATA_W), .DIR(DIR)) u_chk (.*);

// File: tb/sim_twoslot_byte_stage.sv
module sim_twoslot_byte_stage;
   import twoslot_stage_pkg::*;

   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int checks = 0;
   int errors = 0;

   // transmit instance signals
   logic         t_flush = 0, t_dma = 0, t_hs = 0, t_es = 0;
   logic [W-1:0] t_wd = '0, t_ew = '0;
   logic [W-1:0] t_rd, t_er;
   logic         t_ack, t_nack, t_ovf, t_irq, t_dreq;
   logic [1:0]   t_lvl;

   // receive instance signals
   logic         r_flush = 0, r_dma = 0, r_hs = 0, r_es = 0;
   logic [W-1:0] r_wd = '0, r_ew = '0;
   logic [W-1:0] r_rd, r_er;
   logic         r_ack, r_nack, r_ovf, r_irq, r_dreq;
   logic [1:0]   r_lvl;

   twoslot_byte_stage #(.DATA_W(W), .DIR(STAGE_TX)) u0 (
      .clk(clk), .rst_n(rst_n), .flush_i(t_flush), .dma_mode_i(t_dma),
      .host_stb_i(t_hs), .host_wdata_i(t_wd), .host_rdata_o(t_rd),
      .eng_stb_i(t_es), .eng_wdata_i(t_ew), .eng_rdata_o(t_er),
      .eng_ack_o(t_ack), .eng_nack_o(t_nack), .level_o(t_lvl),
      .overflow_o(t_ovf), .irq_req_o(t_irq), .dma_req_o(t_dreq));

   twoslot_byte_stage #(.DATA_W(W), .DIR(STAGE_RX)) u1 (
      .clk(clk), .rst_n(rst_n), .flush_i(r_flush), .dma_mode_i(r_dma),
      .host_stb_i(r_hs), .host_wdata_i(r_wd), .host_rdata_o(r_rd),
      .eng_stb_i(r_es), .eng_wdata_i(r_ew), .eng_rdata_o(r_er),
      .eng_ack_o(r_ack), .eng_nack_o(r_nack), .level_o(r_lvl),
      .overflow_o(r_ovf), .irq_req_o(r_irq), .dma_req_o(r_dreq));

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // transmit vector: flush, push, data, pull, ack, nack, out byte, level after, head after
   typedef struct packed {
      logic       fl;
      logic       ps;
      logic [7:0] d;
      logic       pl;
      logic       ack;
      logic       nack;
      logic [7:0] out;
      logic [1:0] lvl;
      logic [7:0] head;
   } tx_vec_t;

   localparam int NV = 11;
   localparam tx_vec_t TXV [NV] = '{
      '{1'b0, 1'b1, 8'hA1, 1'b0, 1'b0, 1'b0, 8'h00, 2'd1, 8'hA1},  // R2 push into empty
      '{1'b0, 1'b1, 8'hB2, 1'b0, 1'b0, 1'b0, 8'h00, 2'd2, 8'hA1},  // R3 second slot
      '{1'b0, 1'b1, 8'hC3, 1'b0, 1'b0, 1'b0, 8'h00, 2'd2, 8'hA1},  // R3 overwrite newer
      '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'hA1, 2'd1, 8'hC3},  // R4 pull
      '{1'b0, 1'b1, 8'hD4, 1'b1, 1'b1, 1'b0, 8'hC3, 2'd1, 8'hD4},  // R4 pull+push at level 1
      '{1'b0, 1'b1, 8'hE5, 1'b0, 1'b0, 1'b0, 8'h00, 2'd2, 8'hD4},  // R3 fill
      '{1'b0, 1'b1, 8'hF6, 1'b1, 1'b1, 1'b0, 8'hD4, 2'd2, 8'hE5},  // R4 pull+push at full
      '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'hE5, 2'd1, 8'hF6},  // R4 pull
      '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'hF6, 2'd0, 8'h00},  // R4 drain
      '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 2'd0, 8'h00},  // R4 underrun
      '{1'b1, 1'b1, 8'h77, 1'b1, 1'b0, 1'b0, 8'h00, 2'd0, 8'h00}   // R8 flush wins
   };

   initial begin
      #100000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "tx level", t_lvl, 0);
      chk("R1", "tx irq", t_irq, 1);
      chk("R1", "rx level", r_lvl, 0);
      chk("R1", "rx irq", r_irq, 0);
      chk("R1", "rx overflow", r_ovf, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // transmit table walk
      for (int i = 0; i < NV; i++) begin
         t_flush = TXV[i].fl; t_hs = TXV[i].ps; t_wd = TXV[i].d; t_es = TXV[i].pl;
         #1;
         chk("R4", $sformatf("v%0d ack", i), t_ack, TXV[i].ack);
         chk("R4", $sformatf("v%0d nack", i), t_nack, TXV[i].nack);
         if (TXV[i].ack) chk("R4", $sformatf("v%0d out", i), t_er, TXV[i].out);
         @(negedge clk);
         t_flush = 0; t_hs = 0; t_es = 0;
         chk("R9", $sformatf("v%0d level", i), t_lvl, TXV[i].lvl);
         if (TXV[i].lvl != 0) chk("R3", $sformatf("v%0d head", i), t_er, TXV[i].head);
         chk("R7", $sformatf("v%0d irq", i), t_irq, (TXV[i].lvl < 2) ? 1 : 0);
      end

      // R7 tx routing in DMA mode at full
      t_hs = 1; t_wd = 8'h11; @(negedge clk); t_wd = 8'h22; @(negedge clk); t_hs = 0;
      t_dma = 1; #1;
      chk("R7", "tx full dma_req", t_dreq, 0);
      t_es = 1; @(negedge clk); t_es = 0;
      chk("R7", "tx room dma_req", t_dreq, 1);
      chk("R7", "tx room irq masked", t_irq, 0);
      // R8 flush with push
      t_flush = 1; t_hs = 1; t_wd = 8'h99; @(negedge clk); t_flush = 0; t_hs = 0;
      chk("R8", "tx flushed level", t_lvl, 0);

      // receive directed
      r_es = 1; r_ew = 8'h11; #1; chk("R5", "rx ack first", r_ack, 1);
      @(negedge clk); r_ew = 8'h22; @(negedge clk); r_es = 0;
      chk("R5", "rx level 2", r_lvl, 2);
      chk("R5", "rx oldest", r_rd, 8'h11);
      r_es = 1; r_ew = 8'h33; #1;
      chk("R6", "refuse nack", r_nack, 1);
      chk("R6", "refuse ack", r_ack, 0);
      @(negedge clk); r_es = 0;
      chk("R6", "overflow set", r_ovf, 1);
      chk("R6", "contents kept", r_rd, 8'h11);
      chk("R6", "level kept", r_lvl, 2);
      r_hs = 1; @(negedge clk); r_hs = 0;
      chk("R5", "after pop", r_rd, 8'h22);
      chk("R5", "after pop level", r_lvl, 1);
      r_hs = 1; r_es = 1; r_ew = 8'h44; @(negedge clk); r_hs = 0;
      chk("R5", "pop+arrive lvl1", r_rd, 8'h44);
      r_ew = 8'h55; @(negedge clk);
      r_hs = 1; r_ew = 8'h66; #1;
      chk("R6", "pop at full accepts", r_ack, 1);
      @(negedge clk); r_hs = 0; r_es = 0;
      chk("R6", "after pop+arrive", r_rd, 8'h55);
      chk("R6", "still full", r_lvl, 2);
      chk("R6", "overflow sticky", r_ovf, 1);
      r_hs = 1; @(negedge clk); r_hs = 0;
      chk("R5", "order kept", r_rd, 8'h66);
      r_flush = 1; r_es = 1; r_ew = 8'h77; #1;
      chk("R8", "flush no ack", r_ack, 0);
      chk("R8", "flush no nack", r_nack, 0);
      @(negedge clk); r_flush = 0; r_es = 0;
      chk("R8", "rx flushed", r_lvl, 0);
      chk("R8", "overflow cleared", r_ovf, 0);
      chk("R7", "rx empty irq", r_irq, 0);
      r_dma = 1; r_es = 1; r_ew = 8'h88; @(negedge clk); r_es = 0;
      chk("R7", "rx dma_req", r_dreq, 1);
      chk("R7", "rx irq masked", r_irq, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule